// File: doc/BRIEF.md
# Bank-Interleaved Memory Request Controller

This block sits in front of a memory split into several independent banks. Requestors present one word request per cycle on a shared port. Each request is either a fetch or a store and carries the requestor's identity and an access key. The low bits of the word address pick the bank, and the remaining bits pick the row inside it. Consecutive words therefore land in different banks, and their accesses can overlap in time. Each bank is a unit that is busy for a fixed number of cycles per access.

Every accepted request enters an age-ordered queue of outstanding work. An entry leaves the queue when its bank is free and no older entry targets the same word. This keeps fetches and stores to one address in program order. A new fetch that finds an identical fetch still waiting can join it, so one bank access serves both requestors. Each request is checked against an address-region key before it enters the queue, and a violation is reported instead of performed. Fetched words come back with a bit mask that names every requestor that asked for them.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank of a word is its address modulo NBANK, which is the low log2(NBANK) address bits; NBANK is a power of two. The row is the remaining upper bits. Two fetches to different banks accepted on consecutive edges respond on consecutive cycles.
- R2: A fetch to an idle bank with an empty queue appears on the response outputs BUSY+2 clock edges after the edge that accepted it. A bank starts a new access BUSY+1 edges after its previous start, so back-to-back fetches to one bank respond BUSY+1 cycles apart.
- R3: Every accepted fetch that passes the key check is answered exactly once. A request that meets a busy bank waits and is never dropped.
- R4: `req_ready` is high after reset and low while QDEPTH (default 8) requests are held. A request presented while it is low is not taken.
- R5: At most one bank access starts per cycle. The oldest queued request whose bank is free and whose address has no older queued entry starts first, so queued fetches to one bank are answered in acceptance order.
- R6: A fetch returns the value of the most recent store to the same word accepted before it. It never returns the value of a store accepted after it.
- R7: A fetch is merged in one case only. The youngest queued entry for the same word must be a fetch that has not started and does not already include this requestor. The merged fetch produces a single response with both requestors' mask bits set.
- R8: A repeated fetch from the same requestor, or a fetch whose youngest same-word entry is a store, is not merged. It gets a response of its own.
- R9: The region of an address is its top KW bits (default bits 7:6). Key 0 may access every region; any other key may access only the region equal to its value. A violating request is accepted but produces `err_valid` with `err_id` one edge later. It has no effect on memory and produces no data response.
- R10: A response is a one-cycle `rsp_valid` pulse. Bit i of `rsp_mask` names requestor i, `rsp_addr` is the word address, and `rsp_data` is the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue has room; request taken when both are high |
| req_store | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_id | input | log2(NREQ) | Requestor identity |
| req_key | input | KW | Access key |
| rsp_valid | output | 1 | Fetched word present |
| rsp_mask | output | NREQ | Requestors receiving the word |
| rsp_addr | output | AW | Address of the returned word |
| rsp_data | output | DW | Returned word |
| err_valid | output | 1 | Key violation report |
| err_id | output | log2(NREQ) | Requestor of the rejected request |

## Verification
The bench measures the response latency of a lone fetch and the spacing between responses for same-bank and different-bank pairs. A design that decoded the bank from the wrong bits, or released a bank early or late, would respond at the wrong cycle. Three-request patterns stress merging: one where a merge is legal, one where the same requestor repeats, and one where a store sits between two fetches. A design that merged too freely would drop a response, and one that merged across a store would return the older value. Filling a single bank's queue past its depth shows whether ready falls and whether draining preserves age order. Stores with the wrong key, followed by fetches with a legal key, expose a violation that leaked into memory.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/ilv_req_queue.sv
module ilv_req_queue #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NREQ   = 4,
  parameter int NBANK  = 4,
  parameter int QDEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  ilv_pkg::op_e            in_op,
  input  logic [AW-1:0]           in_addr,
  input  logic [DW-1:0]           in_wdata,
  input  logic [$clog2(NREQ)-1:0] in_id,
  input  logic [NBANK-1:0]        bank_busy,
  output logic                    not_full,
  output logic                    iss_vld,
  output ilv_pkg::op_e            iss_op,
  output logic [AW-1:0]           iss_addr,
  output logic [DW-1:0]           iss_wdata,
  output logic [NREQ-1:0]         iss_mask,
  output logic [$clog2(NBANK)-1:0] iss_bank
);
  import ilv_pkg::*;

  localparam int BW  = $clog2(NBANK);
  localparam int QIW = $clog2(QDEPTH);
  localparam int CW  = $clog2(QDEPTH + 1);

  // Entry QDEPTH is a permanent empty slot that feeds the shift.
  logic [QDEPTH:0] q_vld;
  op_e             q_op   [QDEPTH+1];
  logic [AW-1:0]   q_addr [QDEPTH+1];
  logic [DW-1:0]   q_wd   [QDEPTH+1];
  logic [NREQ-1:0] q_mask [QDEPTH+1];
  logic [CW-1:0]   cnt;

  logic [QDEPTH-1:0] elig;
  logic [QIW-1:0]    iss_idx;
  logic              m_hit;
  logic [QIW-1:0]    m_idx;
  logic [QIW-1:0]    m_dst;
  logic [QIW-1:0]    tail;
  logic              do_merge;
  logic              do_app;
  logic [NREQ-1:0]   id_bit;

  // eligibility: bank free and no older entry on the same word
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      elig[i] = q_vld[i] && !bank_busy[q_addr[i][BW-1:0]];
      for (int j = 0; j < i; j++) begin
        if (q_vld[j] && (q_addr[j] == q_addr[i])) elig[i] = 1'b0;
      end
    end
  end

  // oldest eligible entry wins
  always_comb begin
    iss_vld = 1'b0;
    iss_idx = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        iss_vld = 1'b1;
        iss_idx = QIW'(i);
      end
    end
  end

  assign iss_op    = q_op[iss_idx];
  assign iss_addr  = q_addr[iss_idx];
  assign iss_wdata = q_wd[iss_idx];
  assign iss_mask  = q_mask[iss_idx];
  assign iss_bank  = q_addr[iss_idx][BW-1:0];

  // youngest queued entry on the incoming word
  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (q_vld[i] && (q_addr[i] == in_addr)) begin
        m_hit = 1'b1;
        m_idx = QIW'(i);
      end
    end
  end

  assign id_bit   = NREQ'(1) << in_id;
  assign do_merge = in_vld && (in_op == OP_FETCH) && m_hit &&
                    (q_op[m_idx] == OP_FETCH) &&
                    !(iss_vld && (iss_idx == m_idx)) &&
                    !q_mask[m_idx][in_id];
  assign do_app   = in_vld && !do_merge;
  assign m_dst    = (iss_vld && (m_idx > iss_idx)) ? m_idx - QIW'(1) : m_idx;
  assign tail     = QIW'(cnt - CW'(iss_vld));
  assign not_full = (cnt != CW'(QDEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      q_vld <= '0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (iss_vld && (i >= int'(iss_idx))) begin
          q_vld[i]  <= q_vld[i+1];
          q_op[i]   <= q_op[i+1];
          q_addr[i] <= q_addr[i+1];
          q_wd[i]   <= q_wd[i+1];
          q_mask[i] <= q_mask[i+1];
        end
      end
      if (do_merge) q_mask[m_dst] <= q_mask[m_idx] | id_bit;
      if (do_app) begin
        q_vld[tail]  <= 1'b1;
        q_op[tail]   <= in_op;
        q_addr[tail] <= in_addr;
        q_wd[tail]   <= in_wdata;
        q_mask[tail] <= id_bit;
      end
      cnt <= cnt - CW'(iss_vld) + CW'(do_app);
    end
  end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NREQ  = 4,
  parameter int NBANK = 4,
  parameter int BUSY  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  ilv_pkg::op_e    start_op,
  input  logic [AW-1:0]   start_addr,
  input  logic [DW-1:0]   start_wdata,
  input  logic [NREQ-1:0] start_mask,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rd_data,
  output logic [NREQ-1:0] done_mask,
  output logic [AW-1:0]   done_addr
);
  import ilv_pkg::*;

  localparam int BW   = $clog2(NBANK);
  localparam int RW   = AW - BW;
  localparam int ROWS = 1 << RW;
  localparam int TW   = $clog2(BUSY + 1);

  logic [TW-1:0]   tmr;
  op_e             cur_op;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   cur_wd;
  logic [NREQ-1:0] cur_mask;
  logic            fire;
  logic [DW-1:0]   mem [ROWS];

  assign fire = (tmr == TW'(1));
  assign busy = (tmr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr  <= '0;
      done <= 1'b0;
    end else begin
      done <= fire && (cur_op == OP_FETCH);
      if (start)          tmr <= TW'(BUSY);
      else if (tmr != '0) tmr <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      cur_op   <= start_op;
      cur_addr <= start_addr;
      cur_wd   <= start_wdata;
      cur_mask <= start_mask;
    end
  end

  // single-port array, one access at the end of the busy window
  always_ff @(posedge clk) begin
    if (fire && (cur_op == OP_STORE)) mem[cur_addr[AW-1:BW]] <= cur_wd;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      rd_data   <= mem[cur_addr[AW-1:BW]];
      done_mask <= cur_mask;
      done_addr <= cur_addr;
    end
  end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NREQ   = 4,
  parameter int NBANK  = 4,
  parameter int BUSY   = 4,
  parameter int QDEPTH = 8,
  parameter int KW     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_store,
  input  logic [AW-1:0]           req_addr,
  input  logic [DW-1:0]           req_wdata,
  input  logic [$clog2(NREQ)-1:0] req_id,
  input  logic [KW-1:0]           req_key,
  output logic                    rsp_valid,
  output logic [NREQ-1:0]         rsp_mask,
  output logic [AW-1:0]           rsp_addr,
  output logic [DW-1:0]           rsp_data,
  output logic                    err_valid,
  output logic [$clog2(NREQ)-1:0] err_id
);
  import ilv_pkg::*;

  localparam int BW  = $clog2(NBANK);
  localparam int IDW = $clog2(NREQ);

  logic            accept;
  logic            key_ok;
  op_e             in_op;
  logic            iss_vld;
  op_e             iss_op;
  logic [AW-1:0]   iss_addr;
  logic [DW-1:0]   iss_wdata;
  logic [NREQ-1:0] iss_mask;
  logic [BW-1:0]   iss_bank;
  logic [NBANK-1:0] busy_vec;
  logic [NBANK-1:0] done_vec;
  logic [DW-1:0]   bank_rd   [NBANK];
  logic [NREQ-1:0] bank_mask [NBANK];
  logic [AW-1:0]   bank_addr [NBANK];
  logic [NREQ-1:0] sel_mask;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_data;

  assign accept = req_valid && req_ready;
  assign key_ok = (req_key == '0) || (req_key == req_addr[AW-1 -: KW]);
  assign in_op  = req_store ? OP_STORE : OP_FETCH;

  ilv_req_queue #(
    .AW(AW), .DW(DW), .NREQ(NREQ), .NBANK(NBANK), .QDEPTH(QDEPTH)
  ) queue_i (
    .clk(clk), .rst(rst),
    .in_vld(accept && key_ok), .in_op(in_op), .in_addr(req_addr),
    .in_wdata(req_wdata), .in_id(req_id),
    .bank_busy(busy_vec), .not_full(req_ready),
    .iss_vld(iss_vld), .iss_op(iss_op), .iss_addr(iss_addr),
    .iss_wdata(iss_wdata), .iss_mask(iss_mask), .iss_bank(iss_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(
      .AW(AW), .DW(DW), .NREQ(NREQ), .NBANK(NBANK), .BUSY(BUSY)
    ) bank_i (
      .clk(clk), .rst(rst),
      .start(iss_vld && (iss_bank == BW'(b))),
      .start_op(iss_op), .start_addr(iss_addr),
      .start_wdata(iss_wdata), .start_mask(iss_mask),
      .busy(busy_vec[b]), .done(done_vec[b]),
      .rd_data(bank_rd[b]), .done_mask(bank_mask[b]), .done_addr(bank_addr[b])
    );
  end

  // one issue per cycle and a fixed busy time keep completions apart
  always_comb begin
    sel_mask = '0;
    sel_addr = '0;
    sel_data = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (done_vec[b]) begin
        sel_mask = bank_mask[b];
        sel_addr = bank_addr[b];
        sel_data = bank_rd[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_mask  <= '0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
      err_valid <= 1'b0;
      err_id    <= '0;
    end else begin
      rsp_valid <= |done_vec;
      rsp_mask  <= sel_mask;
      rsp_addr  <= sel_addr;
      rsp_data  <= sel_data;
      err_valid <= accept && !key_ok;
      err_id    <= accept ? req_id : IDW'(0);
    end
  end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int NREQ  = 4,
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             err_valid,
  input logic             rsp_valid,
  input logic [NREQ-1:0]  rsp_mask,
  input logic             iss_vld,
  input logic [BW-1:0]    iss_bank,
  input logic [NBANK-1:0] busy_vec,
  input logic [NBANK-1:0] done_vec
);
  // R5
  one_done_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_vec));

  // R2
  free_bank_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld |-> !busy_vec[iss_bank]);

  // R2
  held_busy_chk: assert property (@(posedge clk) disable iff (rst)
    iss_vld |=> busy_vec[$past(iss_bank)]);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(req_valid && req_ready));

  // R10
  rsp_target_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_mask != '0));

  // R10
  rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(|done_vec));
endmodule

bind ilv_mem_ctrl ilv_mem_chk #(.NREQ(NREQ), .NBANK(NBANK), .BW(BW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .err_valid(err_valid), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
  .iss_vld(iss_vld), .iss_bank(iss_bank), .busy_vec(busy_vec),
  .done_vec(done_vec)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_store;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_id, req_key;
  logic        rsp_valid, err_valid;
  logic [3:0]  rsp_mask;
  logic [7:0]  rsp_addr;
  logic [15:0] rsp_data;
  logic [1:0]  err_id;

  always #5 clk = ~clk;

  ilv_mem_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_id(req_id), .req_key(req_key), .rsp_valid(rsp_valid),
    .rsp_mask(rsp_mask), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .err_valid(err_valid), .err_id(err_id)
  );

  typedef struct { int id; int addr; logic [15:0] data; } exp_t;
  typedef struct { int addr; int mask; int t; } log_t;

  logic [15:0] ref_mem [256];
  exp_t exp_q[$];
  int   err_id_q[$];
  int   err_at_q[$];
  log_t rsp_log[$];
  int   pcnt = 0;
  int   compared = 0;
  int   mismatched = 0;
  bit   saw_full = 0;
  bit   done_flag = 0;

  always @(posedge clk) pcnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit st, input int addr, input int wd,
                      input int id, input int key);
    @(negedge clk);
    req_valid = 1'b1;
    req_store = st;
    req_addr  = addr[7:0];
    req_wdata = wd[15:0];
    req_id    = id[1:0];
    req_key   = key[1:0];
    while (!req_ready) begin
      saw_full = 1;
      @(negedge clk);
    end
    if (!(key == 0 || key == (addr >> 6))) begin
      err_id_q.push_back(id);
      err_at_q.push_back(pcnt + 1);
    end else if (st) begin
      ref_mem[addr] = wd[15:0];
    end else begin
      exp_q.push_back('{id: id, addr: addr, data: ref_mem[addr]});
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // scoreboard on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        rsp_log.push_back('{addr: int'(rsp_addr), mask: int'(rsp_mask), t: pcnt});
        for (int b = 0; b < 4; b++) begin
          if (rsp_mask[b]) begin
            int idx;
            idx = -1;
            for (int i = 0; i < exp_q.size(); i++)
              if (idx < 0 && exp_q[i].id == b && exp_q[i].addr == int'(rsp_addr)) idx = i;
            if (idx < 0) begin
              chk(0, "R10", "unexpected response", int'(rsp_addr), -1);
            end else begin
              chk(rsp_data == exp_q[idx].data, "R6", "fetched data",
                  int'(rsp_data), int'(exp_q[idx].data));
              exp_q.delete(idx);
            end
          end
        end
      end
      if (err_at_q.size() > 0 && err_at_q[0] == pcnt) begin
        chk(err_valid && int'(err_id) == err_id_q[0], "R9", "key error id",
            err_valid ? int'(err_id) : -1, err_id_q[0]);
        void'(err_at_q.pop_front());
        void'(err_id_q.pop_front());
      end else if (err_valid) begin
        chk(0, "R9", "spurious key error", int'(err_id), -1);
      end
    end
  end

  task automatic pair_gap(input int a0, input int a1, input int exp_gap, input string req);
    rsp_log.delete();
    send(0, a0, 0, 0, 0);
    send(0, a1, 0, 1, 0);
    idle(20);
    if (rsp_log.size() == 2)
      chk(rsp_log[1].t - rsp_log[0].t == exp_gap, req, "response gap",
          rsp_log[1].t - rsp_log[0].t, exp_gap);
    else
      chk(0, req, "response count", rsp_log.size(), 2);
  endtask

  task automatic count_addr(input int a, input int exp_n, input int exp_mask, input string req);
    int n;
    bit mask_ok;
    n = 0;
    mask_ok = 1;
    foreach (rsp_log[i]) if (rsp_log[i].addr == a) begin
      n++;
      if (rsp_log[i].mask != exp_mask) mask_ok = 0;
    end
    chk(n == exp_n, req, "responses for word", n, exp_n);
    chk(mask_ok, req, "response mask", mask_ok, 1);
  endtask

  initial begin
    req_valid = 0; req_store = 0; req_addr = 0; req_wdata = 0; req_id = 0; req_key = 0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R4", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
    chk(err_valid == 1'b0, "R9", "err_valid after reset", err_valid, 0);

    // preload every word
    for (int a = 0; a < 256; a++) send(1, a, (a * 37 + 5) & 16'hFFFF, a % 4, 0);
    idle(12);

    // R2 latency of a lone fetch
    begin
      int k;
      send(0, 5, 0, 1, 0);
      k = 0;
      do begin @(negedge clk); k++; end while (!rsp_valid && k < 30);
      chk(k == BUSY + 3, "R2", "lone fetch latency (negedges)", k, BUSY + 3);
      idle(4);
    end

    // R1 / R2 bank mapping through response spacing
    pair_gap(8, 12, BUSY + 1, "R2");
    pair_gap(9, 14, 1, "R1");
    pair_gap(16, 21, 1, "R1");
    pair_gap(3, 7, BUSY + 1, "R1");

    // R7 merge of a waiting fetch from another requestor
    rsp_log.delete();
    send(0, 4, 0, 0, 0);
    send(0, 0, 0, 1, 0);
    send(0, 0, 0, 2, 0);
    idle(30);
    count_addr(0, 1, 4'b0110, "R7");

    // R8 same requestor twice: no merge
    rsp_log.delete();
    send(0, 4, 0, 0, 0);
    send(0, 0, 0, 3, 0);
    send(0, 0, 0, 3, 0);
    idle(30);
    count_addr(0, 2, 4'b1000, "R8");

    // R6 / R8 store between two fetches of one word
    rsp_log.delete();
    send(0, 4, 0, 0, 0);
    send(0, 0, 0, 1, 0);
    send(1, 0, 16'hBEEF, 2, 0);
    send(0, 0, 0, 3, 0);
    send(1, 1, 16'h1234, 2, 0);
    send(0, 1, 0, 0, 0);
    idle(40);
    chk(exp_q.size() == 0, "R6", "ordered fetches answered", exp_q.size(), 0);
    begin
      int n;
      n = 0;
      foreach (rsp_log[i]) if (rsp_log[i].addr == 0) n++;
      chk(n == 2, "R8", "no merge across store", n, 2);
    end

    // R9 key checks
    send(1, 8'h45, 16'hDEAD, 1, 2);
    send(0, 8'h45, 0, 2, 1);
    send(0, 8'h80, 0, 3, 1);
    send(0, 8'hC0, 0, 0, 3);
    idle(20);
    chk(err_at_q.size() == 0, "R9", "all key errors reported", err_at_q.size(), 0);
    chk(exp_q.size() == 0, "R9", "legal keyed fetches answered", exp_q.size(), 0);

    // R4 / R5 fill one bank's queue
    saw_full = 0;
    rsp_log.delete();
    for (int i = 0; i < 14; i++) send(0, 4 * i, 0, i % 4, 0);
    idle(90);
    chk(saw_full == 1, "R4", "ready dropped when queue full", saw_full, 1);
    begin
      bit ord_ok;
      ord_ok = (rsp_log.size() == 14);
      foreach (rsp_log[i]) if (rsp_log[i].addr != 4 * i) ord_ok = 0;
      chk(ord_ok, "R5", "same-bank fetches in acceptance order", rsp_log.size(), 14);
    end

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a, r;
      r = $urandom_range(0, 3);
      a = $urandom_range(0, 15) | (r << 6);
      send($urandom_range(0, 9) < 3, a, $urandom_range(0, 65535),
           $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 6));
    end
    begin
      int w;
      w = 0;
      while ((exp_q.size() > 0 || err_at_q.size() > 0) && w < 400) begin
        @(posedge clk);
        w++;
      end
    end
    idle(5);
    chk(exp_q.size() == 0, "R3", "outstanding fetches after drain", exp_q.size(), 0);
    chk(err_at_q.size() == 0, "R9", "outstanding key errors after drain", err_at_q.size(), 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule